// File: doc/BRIEF.md
# Op-Code Register Loader with Program Sequencer

This block fills a bank of sixteen 8-bit configuration registers from a byte stream of instructions. Each instruction is one op-code byte followed by one to sixteen data bytes. The op-code names the first register and the number of data bytes. The data bytes then land in consecutive registers. The stream has two sources. A host can write it live once it has been granted access through an active-low request and an acknowledge. Otherwise a sequencer replays a program held in an external 32K×8 byte RAM, one instruction for each step trigger.

The same host port also manages the program RAM. The host sets a 15-bit start address, which also loads the shared RAM address counter, and then stores program bytes one per strobe with automatic increment. A reserved end code in a program sends the counter back to the start address, so a sweep of many steps repeats without host help. The host and the sequencer never use the byte path at the same time. The acknowledge is held back while an instruction is being replayed, and a step trigger waits while the host holds the acknowledge.

Top module: `cfg_seq_loader`

## Requirements
- R1: While reset is active, every configuration register reads 0, `host_ack` is 0, `ram_we` is 0 and `ram_addr` is 0.
- R2: `host_ack` rises one clock after `host_req_n` is sampled low while the sequencer is idle, and falls one clock after `host_req_n` is sampled high.
- R3: A host write (`host_wr`) made while `host_ack` is low has no effect: no register changes, `ram_we` stays 0 and `ram_addr` is unchanged.
- R4: With `host_sel` = 0, the host byte enters the instruction stream. In an op-code byte, bits [7:4] hold the index of the first register and bits [3:0] hold the data-byte count minus one. Data byte i goes to register (first + i) mod 16, and register k appears on `cfg_regs[8k+7:8k]`.
- R5: With `host_sel` = 1, the host writes the low 8 bits of the start address. With `host_sel` = 2, it writes the upper 7 bits from `host_wdata[6:0]`, and that write also loads the address counter with the full start address, which `ram_addr` then shows.
- R6: With `host_sel` = 3, `ram_we` is high in the strobe cycle with `ram_wdata` = `host_wdata` at the current `ram_addr`. The address then advances by one.
- R7: Each step trigger makes the sequencer read exactly one instruction from RAM, starting at the current address, one byte per clock. It writes the registers as in R4 and leaves `ram_addr` just past the last data byte.
- R8: An op-code value of 0xFF read by the sequencer reloads the counter from the start address and reading continues in the same step. A second 0xFF in the same step ends the step with nothing written. A 0xFF sent by the host as an op-code is discarded, and the following byte is taken as a new op-code.
- R9: If a step trigger and a falling `host_req_n` are sampled in the same clock, the sequencer wins. `host_ack` stays low until the instruction has been consumed and rises on the following clock.
- R10: A step trigger that arrives while `host_ack` is high is held. It runs only after the host has released the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_n | input | 1 | Active-low host access request |
| host_ack | output | 1 | Host access granted |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 2 | Host write target: 0 stream, 1 start low, 2 start high, 3 program byte |
| host_wdata | input | 8 | Host write byte |
| step | input | 1 | Sequencer step trigger |
| ram_addr | output | 15 | Program RAM address (address counter) |
| ram_wdata | output | 8 | Program RAM write data |
| ram_we | output | 1 | Program RAM write enable |
| ram_rdata | input | 8 | Program RAM read data, combinational from `ram_addr` |
| cfg_regs | output | 128 | Configuration register bank, register k at bits [8k+7:8k] |

## Verification
Two functions can fall in the same clock edge: a step trigger starting a replay and a host request asking for the shared byte path. The bench drives both in the same cycle. It then checks that the acknowledge stays low for exactly the length of the replayed instruction plus the start cycle, that it rises on the clock after, and that the RAM address lands past that instruction. The reverse case is also covered. A step raised while the host holds the acknowledge must leave the registers and address untouched until the request is dropped, and then it must run.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   typedef enum logic [1:0] {
      SEL_STREAM   = 2'd0,
      SEL_START_LO = 2'd1,
      SEL_START_HI = 2'd2,
      SEL_PROG     = 2'd3
   } host_sel_e;

endpackage

// File: rtl/cfg_byte_parser.sv
module cfg_byte_parser #(
   parameter int DATA_W   = 8,
   parameter int NUM_REGS = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [DATA_W-1:0]            in_byte,
   output logic                         at_boundary,
   output logic                         instr_done,
   output logic                         end_mark,
   output logic [NUM_REGS*DATA_W-1:0]   regs_flat
);
   localparam int IDX_W = $clog2(NUM_REGS);
   localparam int CNT_W = DATA_W - IDX_W;
   localparam logic [DATA_W-1:0] END_CODE = '1;

   if (NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("NUM_REGS must be a power of two");
   end
   if (IDX_W < 1 || CNT_W < 1) begin : g_bad_split
      $error("op-code byte cannot hold index and count");
   end

   logic             bound_q;
   logic [IDX_W-1:0] ptr_q;
   logic [CNT_W-1:0] rem_q;

   assign at_boundary = bound_q;
   assign end_mark    = in_valid && bound_q && (in_byte == END_CODE);
   assign instr_done  = in_valid && !bound_q && (rem_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bound_q <= 1'b1;
         ptr_q   <= '0;
         rem_q   <= '0;
      end else if (in_valid) begin
         if (bound_q) begin
            if (in_byte != END_CODE) begin
               ptr_q   <= in_byte[DATA_W-1 -: IDX_W];
               rem_q   <= in_byte[CNT_W-1:0];
               bound_q <= 1'b0;
            end
         end else begin
            ptr_q <= ptr_q + 1'b1;
            if (rem_q == '0) begin
               bound_q <= 1'b1;
            end else begin
               rem_q <= rem_q - 1'b1;
            end
         end
      end
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
      logic [DATA_W-1:0] val_q;
      logic              we;
      assign we = in_valid && !bound_q && (ptr_q == IDX_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= '0;
         end else if (we) begin
            val_q <= in_byte;
         end
      end
      assign regs_flat[g*DATA_W +: DATA_W] = val_q;
   end

endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     lo_we,
   input  logic                     hi_we,
   input  logic [DATA_W-1:0]        lo_data,
   input  logic [ADDR_W-DATA_W-1:0] hi_data,
   input  logic                     reload,
   input  logic                     inc,
   output logic [ADDR_W-1:0]        addr
);
   localparam int HI_W = ADDR_W - DATA_W;

   if (HI_W < 1 || HI_W > DATA_W) begin : g_bad_addr
      $error("ADDR_W must lie between DATA_W+1 and 2*DATA_W");
   end

   logic [DATA_W-1:0] start_lo_q;
   logic [HI_W-1:0]   start_hi_q;
   logic [ADDR_W-1:0] addr_q;

   assign addr = addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_lo_q <= '0;
         start_hi_q <= '0;
         addr_q     <= '0;
      end else begin
         if (lo_we) start_lo_q <= lo_data;
         if (hi_we) begin
            start_hi_q <= hi_data;
            addr_q     <= {hi_data, start_lo_q};
         end else if (reload) begin
            addr_q <= {start_hi_q, start_lo_q};
         end else if (inc) begin
            addr_q <= addr_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/cfg_seq_ctrl.sv
module cfg_seq_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic host_req_n,
   input  logic step,
   input  logic at_boundary,
   input  logic instr_done,
   input  logic end_mark,
   output logic host_ack,
   output logic busy,
   output logic reload
);
   logic pend_q, busy_q, wrapped_q, ack_q;
   logic start;

   assign start    = (step || pend_q) && !busy_q && !ack_q && at_boundary;
   assign reload   = busy_q && end_mark;
   assign busy     = busy_q;
   assign host_ack = ack_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q    <= 1'b0;
         busy_q    <= 1'b0;
         wrapped_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         if (start)     pend_q <= 1'b0;
         else if (step) pend_q <= 1'b1;

         if (start) begin
            busy_q    <= 1'b1;
            wrapped_q <= 1'b0;
         end else if (busy_q) begin
            if (instr_done || (end_mark && wrapped_q)) busy_q <= 1'b0;
            if (end_mark) wrapped_q <= 1'b1;
         end

         ack_q <= !host_req_n && (ack_q || (!busy_q && !start));
      end
   end

endmodule

// File: rtl/cfg_seq_loader.sv
module cfg_seq_loader #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 15,
   parameter int NUM_REGS = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       host_req_n,
   output logic                       host_ack,
   input  logic                       host_wr,
   input  logic [1:0]                 host_sel,
   input  logic [DATA_W-1:0]          host_wdata,
   input  logic                       step,
   output logic [ADDR_W-1:0]          ram_addr,
   output logic [DATA_W-1:0]          ram_wdata,
   output logic                       ram_we,
   input  logic [DATA_W-1:0]          ram_rdata,
   output logic [NUM_REGS*DATA_W-1:0] cfg_regs
);
   import cfg_loader_pkg::*;

   localparam int HI_W = ADDR_W - DATA_W;

   logic            host_ok;
   host_sel_e       sel;
   logic            seq_busy, seq_reload;
   logic            par_valid;
   logic [DATA_W-1:0] par_byte;
   logic            at_bound, instr_done, end_mark;

   assign sel       = host_sel_e'(host_sel);
   assign host_ok   = host_wr && host_ack;
   assign par_valid = seq_busy || (host_ok && sel == SEL_STREAM);
   assign par_byte  = seq_busy ? ram_rdata : host_wdata;
   assign ram_we    = host_ok && sel == SEL_PROG;
   assign ram_wdata = host_wdata;

   cfg_seq_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .host_req_n  (host_req_n),
      .step        (step),
      .at_boundary (at_bound),
      .instr_done  (instr_done),
      .end_mark    (end_mark),
      .host_ack    (host_ack),
      .busy        (seq_busy),
      .reload      (seq_reload)
   );

   cfg_addr_ctr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_we   (host_ok && sel == SEL_START_LO),
      .hi_we   (host_ok && sel == SEL_START_HI),
      .lo_data (host_wdata),
      .hi_data (host_wdata[HI_W-1:0]),
      .reload  (seq_reload),
      .inc     (ram_we || seq_busy),
      .addr    (ram_addr)
   );

   cfg_byte_parser #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_parse (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (par_valid),
      .in_byte     (par_byte),
      .at_boundary (at_bound),
      .instr_done  (instr_done),
      .end_mark    (end_mark),
      .regs_flat   (cfg_regs)
   );

endmodule

// File: rtl/cfg_seq_loader_chk.sv
module cfg_seq_loader_chk #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 15,
   parameter int NUM_REGS = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       host_req_n,
   input logic                       host_ack,
   input logic                       ram_we,
   input logic [ADDR_W-1:0]          ram_addr,
   input logic [NUM_REGS*DATA_W-1:0] cfg_regs,
   input logic                       busy,
   input logic                       par_valid
);
   AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_ack) |-> $past(!host_req_n));                        // R2
   AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req_n && host_ack) |=> !host_ack);                        // R2
   AST_WE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> host_ack);                                           // R3
   AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !par_valid |=> $stable(cfg_regs));                              // R3
   AST_WE_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> ram_addr == $past(ram_addr) + 1'b1);                 // R6
   AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !host_ack);                                            // R9
endmodule

bind cfg_seq_loader cfg_seq_loader_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .host_req_n (host_req_n),
   .host_ack   (host_ack),
   .ram_we     (ram_we),
   .ram_addr   (ram_addr),
   .cfg_regs   (cfg_regs),
   .busy       (seq_busy),
   .par_valid  (par_valid)
);

// File: tb/cfg_seq_loader_test.sv
module cfg_seq_loader_test;
   logic         clk = 1'b0;
   logic         rst_n;
   logic         host_req_n;
   logic         host_ack;
   logic         host_wr;
   logic [1:0]   host_sel;
   logic [7:0]   host_wdata;
   logic         step;
   logic [14:0]  ram_addr;
   logic [7:0]   ram_wdata;
   logic         ram_we;
   logic [7:0]   ram_rdata;
   logic [127:0] cfg_regs;

   int n_run = 0;
   int n_fail = 0;
   logic [7:0] exp_regs [16];
   logic [7:0] mem [1024];
   logic [7:0] prog [16];

   always #5 clk = ~clk;

   cfg_seq_loader uut (
      .clk(clk), .rst_n(rst_n), .host_req_n(host_req_n), .host_ack(host_ack),
      .host_wr(host_wr), .host_sel(host_sel), .host_wdata(host_wdata),
      .step(step), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_we(ram_we),
      .ram_rdata(ram_rdata), .cfg_regs(cfg_regs)
   );

   assign ram_rdata = mem[ram_addr[9:0]];
   always @(posedge clk) if (ram_we) mem[ram_addr[9:0]] <= ram_wdata;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_flat();
      logic [127:0] f;
      for (int k = 0; k < 16; k++) f[k*8 +: 8] = exp_regs[k];
      return f;
   endfunction

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hwr(input logic [1:0] sel, input logic [7:0] d);
      host_sel = sel; host_wdata = d; host_wr = 1'b1;
      cyc(1);
      host_wr = 1'b0;
   endtask

   task automatic direct_instr(input int first, input int cnt, input int seed, input bit fill0);
      hwr(2'd0, {4'(first), 4'(cnt - 1)});
      for (int i = 0; i < cnt; i++) begin
         logic [7:0] d;
         d = fill0 ? 8'h00 : 8'(seed + i * 7 + 1);
         hwr(2'd0, d);
         exp_regs[(first + i) % 16] = d;
      end
   endtask

   task automatic pulse_step();
      step = 1'b1; cyc(1); step = 1'b0;
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      report();
   end

   initial begin
      int pos;
      int firsts [3];
      int cnts [3];
      for (int k = 0; k < 1024; k++) mem[k] = 8'h00;
      for (int k = 0; k < 16; k++) exp_regs[k] = 8'h00;
      rst_n = 1'b0; host_req_n = 1'b1; host_wr = 1'b0; host_sel = 2'd0;
      host_wdata = 8'h00; step = 1'b0;
      cyc(3);
      // R1 reset state
      chk("R1 regs", cfg_regs, 128'h0);
      chk("R1 ack/we/addr", {112'h0, host_ack, ram_we, ram_addr}, 128'h0);
      rst_n = 1'b1;
      cyc(1);

      // R2 grant
      host_req_n = 1'b0; cyc(1);
      chk("R2 ack rises", {127'h0, host_ack}, 128'h1);

      // R4 sweep over every first index with varied counts, wraps included
      for (int s = 0; s < 16; s++) begin
         direct_instr(s, ((s * 5) % 16) + 1, s * 16, 1'b0);
         chk("R4 direct load", cfg_regs, exp_flat());
      end

      // R8 host 0xFF op-code discarded
      hwr(2'd0, 8'hFF);
      chk("R8 host end code ignored", cfg_regs, exp_flat());
      direct_instr(4, 2, 8'h90, 1'b0);
      chk("R8 next op-code after end code", cfg_regs, exp_flat());

      // R5 start address
      hwr(2'd1, 8'h30);
      chk("R5 low byte alone keeps addr", {113'h0, ram_addr}, 128'h0);
      hwr(2'd2, 8'h5A);
      chk("R5 counter loaded", {113'h0, ram_addr}, {113'h0, 15'h5A30});

      // R6 program store: three instructions then end code
      pos = 0;
      for (int j = 0; j < 3; j++) begin
         firsts[j] = (j * 5 + 3) % 16;
         cnts[j] = j + 2;
         prog[pos] = {4'(firsts[j]), 4'(cnts[j] - 1)}; pos++;
         for (int i = 0; i < cnts[j]; i++) begin
            prog[pos] = 8'(8'h40 + j * 16 + i + 1); pos++;
         end
      end
      prog[pos] = 8'hFF; pos++;
      for (int p = 0; p < pos; p++) begin
         host_sel = 2'd3; host_wdata = prog[p]; host_wr = 1'b1;
         #1;
         chk("R6 we with addr", {112'h0, ram_we, ram_addr}, {112'h0, 1'b1, 15'(15'h5A30 + p)});
         cyc(1); host_wr = 1'b0;
      end
      chk("R6 addr advanced", {113'h0, ram_addr}, {113'h0, 15'(15'h5A30 + pos)});
      chk("R6 ram content", {120'h0, mem[10'h230 + 10'd5]}, {120'h0, prog[5]});
      hwr(2'd2, 8'h5A);

      host_req_n = 1'b1; cyc(1);
      chk("R2 ack falls", {127'h0, host_ack}, 128'h0);

      // R3 writes without ack are ignored
      host_sel = 2'd3; host_wdata = 8'h77; host_wr = 1'b1;
      #1;
      chk("R3 no ram_we without ack", {127'h0, ram_we}, 128'h0);
      cyc(1);
      host_sel = 2'd0; host_wdata = 8'h12; cyc(1);
      host_wdata = 8'h34; cyc(1); host_wr = 1'b0;
      chk("R3 regs untouched", cfg_regs, exp_flat());
      chk("R3 addr untouched", {113'h0, ram_addr}, {113'h0, 15'h5A30});

      // R7 replay each instruction
      pos = 0;
      for (int j = 0; j < 3; j++) begin
         pulse_step();
         cyc(cnts[j] + 4);
         for (int i = 0; i < cnts[j]; i++)
            exp_regs[(firsts[j] + i) % 16] = prog[pos + 1 + i];
         pos += cnts[j] + 1;
         chk("R7 regs after step", cfg_regs, exp_flat());
         chk("R7 addr after step", {113'h0, ram_addr}, {113'h0, 15'(15'h5A30 + pos)});
      end

      // R8 end code wraps to start within the same step
      host_req_n = 1'b0; cyc(1);
      direct_instr(firsts[0], cnts[0], 0, 1'b1);
      host_req_n = 1'b1; cyc(1);
      pulse_step(); cyc(10);
      for (int i = 0; i < cnts[0]; i++) exp_regs[(firsts[0] + i) % 16] = prog[1 + i];
      chk("R8 wrap reloads program", cfg_regs, exp_flat());
      chk("R8 addr after wrap", {113'h0, ram_addr}, {113'h0, 15'h5A33});

      // R9 step and request in the same cycle
      step = 1'b1; host_req_n = 1'b0; cyc(1); step = 1'b0;
      chk("R9 ack withheld", {127'h0, host_ack}, 128'h0);
      cyc(4);
      chk("R9 ack still withheld", {127'h0, host_ack}, 128'h0);
      cyc(1);
      chk("R9 ack after instruction", {127'h0, host_ack}, 128'h1);
      chk("R9 addr after instruction", {113'h0, ram_addr}, {113'h0, 15'h5A37});

      // R10 step while ack held is deferred
      direct_instr(firsts[2], cnts[2], 0, 1'b1);
      pulse_step(); cyc(10);
      chk("R10 regs held", cfg_regs, exp_flat());
      chk("R10 addr held", {113'h0, ram_addr}, {113'h0, 15'h5A37});
      host_req_n = 1'b1; cyc(12);
      for (int i = 0; i < cnts[2]; i++) exp_regs[(firsts[2] + i) % 16] = prog[8 + i];
      chk("R10 deferred step ran", cfg_regs, exp_flat());
      chk("R10 addr after deferred", {113'h0, ram_addr}, {113'h0, 15'h5A3C});

      // R8 start on the end code: second end code finishes the step
      host_req_n = 1'b0; cyc(1);
      hwr(2'd1, 8'h3C); hwr(2'd2, 8'h5A);
      host_req_n = 1'b1; cyc(2);
      pulse_step(); cyc(8);
      chk("R8 double end code regs", cfg_regs, exp_flat());
      chk("R8 double end code addr", {113'h0, ram_addr}, {113'h0, 15'h5A3C});
      host_req_n = 1'b0; cyc(1);
      chk("R8 sequencer idle again", {127'h0, host_ack}, 128'h1);
      host_req_n = 1'b1; cyc(2);

      report();
   end
endmodule